// File: doc/BRIEF.md
# Rotating-Priority Interrupt Controller Core

This block arbitrates eight interrupt request lines. Each line is captured into a request register. A line can be edge triggered, where a rising input sets the request and a falling input leaves it set, or level triggered, where the request follows the input. Pending requests are filtered by a mask register. The surviving set is ranked against the lines already in service, in a circular order that starts at a programmable base line. The single interrupt output rises only when a pending line ranks strictly ahead of everything in service.

An acknowledge strobe takes the line currently presented on the line output. It marks that line in service, or, with automatic end-of-interrupt, may rotate the base instead. It also clears the edge request. A command port carries already-decoded end-of-interrupt and priority-rotation operations. Mode inputs select the following:
- Special mask: masked lines stop counting as in service.
- Fully nested: line 2 of a master unit stops counting as in service.
- Automatic end-of-interrupt.
- Rotation on automatic end-of-interrupt.

Top module: `pic_core`

## Requirements
- R1: An active-low asynchronous reset clears requests, stored levels, in-service bits and mask, sets the base line to 0 and clears all mode flags; afterwards int_o is 0 and the line output shows 7 with the spurious flag set.
- R2: For a line with trig_level_i bit 0, a rising input sets its request bit one clock later. A falling input never clears that request.
- R3: For a line with trig_level_i bit 1, the request bit equals the input as sampled at the previous clock, in both directions.
- R4: int_o is 1 exactly when a request that is not masked has a rank strictly lower than the best in-service rank. While int_o is 1, ack_line_o gives that line.
- R5: Rank of line L is (L - base) mod 8. Rank 0 is highest, so the order starts at the base line and wraps past line 7 to line 0.
- R6: An acknowledge while int_o is 1 sets the line's in-service bit when automatic end-of-interrupt is off. It clears the request of an edge line. It leaves a level line's request set.
- R7: While int_o is 0, ack_line_o is 7 and ack_spurious_o is 1, and an acknowledge changes no state.
- R8: With automatic end-of-interrupt on, an acknowledge sets no in-service bit. If rotation on automatic end-of-interrupt is also on, it sets the base to line+1 mod 8.
- R9: Command 1 clears the highest-ranked in-service bit. Command 2 does the same and also sets the base to that line+1. Both do nothing when no bit is in service.
- R10: Command 3 clears in-service bit cmd_line_i. Command 4 sets the base to cmd_line_i+1 mod 8. Command 5 does both.
- R11: With special mask on, masked in-service lines are left out of the in-service rank.
- R12: With fully nested on and master_i 1, in-service line 2 is left out of the in-service rank.
- R13: Command codes 0, 6 and 7 have no effect. An acknowledge in the same cycle as a command takes precedence, and the command is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| irq_i | input | 8 | Request inputs |
| trig_level_i | input | 8 | Per line: 1 level triggered, 0 edge triggered |
| master_i | input | 1 | Unit acts as master (enables line-2 exclusion) |
| mask_we_i | input | 1 | Load mask register |
| mask_i | input | 8 | Mask value, 1 masks a line |
| cfg_we_i | input | 1 | Load mode flags |
| cfg_smm_i | input | 1 | Special mask mode |
| cfg_nested_i | input | 1 | Fully nested mode |
| cfg_aeoi_i | input | 1 | Automatic end-of-interrupt |
| cfg_rot_aeoi_i | input | 1 | Rotate base on automatic end-of-interrupt |
| cmd_valid_i | input | 1 | Command strobe |
| cmd_op_i | input | 3 | Command code (R9, R10, R13) |
| cmd_line_i | input | 3 | Line operand of the command |
| ack_i | input | 1 | Acknowledge strobe |
| int_o | output | 1 | Interrupt output |
| ack_line_o | output | 3 | Resolved line, 7 when spurious |
| ack_spurious_o | output | 1 | No candidate present |

## Verification
Assertions check these on every cycle:
- Level lines track their input.
- An idle edge line keeps its request.
- An acknowledge either marks the presented line in service or, with automatic end-of-interrupt and rotation, moves the base past it.
- A spurious acknowledge changes nothing.
- In-service bits never multiply without an acknowledge.
- The interrupt output never rises without an unmasked request.

Only the bench's scenarios can show the following:
- The exact winner under a rotated base.
- The interplay of end-of-interrupt commands with later arbitration.
- The effect of special mask and fully nested modes on the current level.

// File: rtl/pic_pkg.sv
package pic_pkg;
  localparam int NUM_LINES = 8;
  localparam int LINE_W    = $clog2(NUM_LINES);
  localparam int RANK_W    = LINE_W + 1;
  localparam logic [LINE_W-1:0] SPUR_LINE    = LINE_W'(NUM_LINES - 1);
  localparam int                CASCADE_LINE = 2;

  typedef enum logic [2:0] {
    CMD_NOP          = 3'd0,
    CMD_EOI_NS       = 3'd1,
    CMD_EOI_NS_ROT   = 3'd2,
    CMD_EOI_SPEC     = 3'd3,
    CMD_SET_BASE     = 3'd4,
    CMD_EOI_SPEC_ROT = 3'd5
  } cmd_op_e;

  // rank of best member of set, NUM_LINES when empty
  function automatic logic [RANK_W-1:0] rank_of(input logic [NUM_LINES-1:0] set,
                                                input logic [LINE_W-1:0]    base);
    logic [RANK_W-1:0] r;
    r = RANK_W'(NUM_LINES);
    for (int i = NUM_LINES - 1; i >= 0; i--) begin
      if (set[LINE_W'(int'(base) + i)]) r = RANK_W'(i);
    end
    return r;
  endfunction

  function automatic logic [LINE_W-1:0] line_of(input logic [RANK_W-1:0] rank,
                                                input logic [LINE_W-1:0] base);
    return LINE_W'(rank) + base;
  endfunction
endpackage

// File: rtl/pic_req_capture.sv
module pic_req_capture
  import pic_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_LINES-1:0] irq_i,
  input  logic [NUM_LINES-1:0] trig_level_i,
  input  logic [NUM_LINES-1:0] ack_clr_i,
  output logic [NUM_LINES-1:0] irr_o
);
  logic [NUM_LINES-1:0] irr_q;
  logic [NUM_LINES-1:0] prev_q;

  for (genvar k = 0; k < NUM_LINES; k++) begin : g_line
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        prev_q[k] <= 1'b0;
        irr_q[k]  <= 1'b0;
      end else begin
        prev_q[k] <= irq_i[k];
        if (trig_level_i[k])            irr_q[k] <= irq_i[k];
        else if (irq_i[k] && !prev_q[k]) irr_q[k] <= 1'b1;
        else if (ack_clr_i[k])           irr_q[k] <= 1'b0;
      end
    end

    // R3
    level_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      trig_level_i[k] |=> irr_q[k] == $past(irq_i[k]));

    // R2
    edge_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!trig_level_i[k] && !ack_clr_i[k]) |=> irr_q[k] >= $past(irr_q[k]));
  end

  assign irr_o = irr_q;
endmodule

// File: rtl/pic_prio_resolve.sv
module pic_prio_resolve
  import pic_pkg::*;
(
  input  logic [NUM_LINES-1:0] irr_i,
  input  logic [NUM_LINES-1:0] imr_i,
  input  logic [NUM_LINES-1:0] isr_i,
  input  logic [LINE_W-1:0]    base_i,
  input  logic                 smm_i,
  input  logic                 nested_i,
  input  logic                 master_i,
  output logic                 int_o,
  output logic [LINE_W-1:0]    line_o,
  output logic                 spurious_o
);
  logic [NUM_LINES-1:0] cand;
  logic [NUM_LINES-1:0] cur;
  logic [RANK_W-1:0]    cand_rank;
  logic [RANK_W-1:0]    cur_rank;

  always_comb begin
    cand = irr_i & ~imr_i;
    cur  = isr_i;
    if (smm_i) cur = cur & ~imr_i;
    if (nested_i && master_i) cur[CASCADE_LINE] = 1'b0;
    cand_rank = rank_of(cand, base_i);
    cur_rank  = rank_of(cur, base_i);
  end

  assign int_o      = cand_rank < cur_rank;
  assign line_o     = int_o ? line_of(cand_rank, base_i) : SPUR_LINE;
  assign spurious_o = !int_o;
endmodule

// File: rtl/pic_service_ctrl.sv
module pic_service_ctrl
  import pic_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 ack_i,
  input  logic                 cmd_valid_i,
  input  logic [2:0]           cmd_op_i,
  input  logic [LINE_W-1:0]    cmd_line_i,
  input  logic                 mask_we_i,
  input  logic [NUM_LINES-1:0] mask_i,
  input  logic                 cfg_we_i,
  input  logic                 cfg_smm_i,
  input  logic                 cfg_nested_i,
  input  logic                 cfg_aeoi_i,
  input  logic                 cfg_rot_aeoi_i,
  input  logic [NUM_LINES-1:0] trig_level_i,
  input  logic                 int_i,
  input  logic [LINE_W-1:0]    line_i,
  output logic [NUM_LINES-1:0] isr_o,
  output logic [NUM_LINES-1:0] imr_o,
  output logic [LINE_W-1:0]    base_o,
  output logic                 smm_o,
  output logic                 nested_o,
  output logic [NUM_LINES-1:0] ack_clr_o
);
  logic [NUM_LINES-1:0] isr_q, imr_q;
  logic [LINE_W-1:0]    base_q;
  logic                 smm_q, nested_q, aeoi_q, rot_q;
  logic                 ack_fire;
  logic [RANK_W-1:0]    top_rank;
  logic [LINE_W-1:0]    top_line;
  logic                 top_hit;

  assign ack_fire = ack_i && int_i;
  assign top_rank = rank_of(isr_q, base_q);
  assign top_line = line_of(top_rank, base_q);
  assign top_hit  = top_rank != RANK_W'(NUM_LINES);

  always_comb begin
    ack_clr_o = '0;
    if (ack_fire && !trig_level_i[line_i]) ack_clr_o[line_i] = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      isr_q    <= '0;
      imr_q    <= '0;
      base_q   <= '0;
      smm_q    <= 1'b0;
      nested_q <= 1'b0;
      aeoi_q   <= 1'b0;
      rot_q    <= 1'b0;
    end else begin
      if (ack_fire) begin
        if (!aeoi_q)    isr_q[line_i] <= 1'b1;
        else if (rot_q) base_q        <= line_i + 1'b1;
      end else if (cmd_valid_i) begin
        unique case (cmd_op_e'(cmd_op_i))
          CMD_EOI_NS, CMD_EOI_NS_ROT: if (top_hit) begin
            isr_q[top_line] <= 1'b0;
            if (cmd_op_e'(cmd_op_i) == CMD_EOI_NS_ROT) base_q <= top_line + 1'b1;
          end
          CMD_EOI_SPEC:     isr_q[cmd_line_i] <= 1'b0;
          CMD_SET_BASE:     base_q <= cmd_line_i + 1'b1;
          CMD_EOI_SPEC_ROT: begin
            isr_q[cmd_line_i] <= 1'b0;
            base_q            <= cmd_line_i + 1'b1;
          end
          default: ;
        endcase
      end
      if (mask_we_i) imr_q <= mask_i;
      if (cfg_we_i) begin
        smm_q    <= cfg_smm_i;
        nested_q <= cfg_nested_i;
        aeoi_q   <= cfg_aeoi_i;
        rot_q    <= cfg_rot_aeoi_i;
      end
    end
  end

  // R6
  ack_marks_isr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && int_i && !aeoi_q) |=> isr_q[$past(line_i)]);

  // R7
  spur_ack_noop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && !int_i && !cmd_valid_i) |=> ($stable(isr_q) && $stable(base_q)));

  // R8
  aeoi_rotate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && int_i && aeoi_q && rot_q) |=>
      (base_q == LINE_W'($past(line_i) + 1'b1) && $stable(isr_q)));

  // R9
  isr_no_growth_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ack_i |=> $countones(isr_q) <= $countones($past(isr_q)));

  // R10
  set_base_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && !ack_i && cmd_op_i == 3'd4) |=>
      base_q == LINE_W'($past(cmd_line_i) + 1'b1));

  assign isr_o    = isr_q;
  assign imr_o    = imr_q;
  assign base_o   = base_q;
  assign smm_o    = smm_q;
  assign nested_o = nested_q;
endmodule

// File: rtl/pic_core.sv
module pic_core
  import pic_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_LINES-1:0] irq_i,
  input  logic [NUM_LINES-1:0] trig_level_i,
  input  logic                 master_i,
  input  logic                 mask_we_i,
  input  logic [NUM_LINES-1:0] mask_i,
  input  logic                 cfg_we_i,
  input  logic                 cfg_smm_i,
  input  logic                 cfg_nested_i,
  input  logic                 cfg_aeoi_i,
  input  logic                 cfg_rot_aeoi_i,
  input  logic                 cmd_valid_i,
  input  logic [2:0]           cmd_op_i,
  input  logic [LINE_W-1:0]    cmd_line_i,
  input  logic                 ack_i,
  output logic                 int_o,
  output logic [LINE_W-1:0]    ack_line_o,
  output logic                 ack_spurious_o
);
  logic [NUM_LINES-1:0] irr, isr, imr, ack_clr;
  logic [LINE_W-1:0]    base;
  logic                 smm, nested;

  pic_req_capture u_capture (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .irq_i        (irq_i),
    .trig_level_i (trig_level_i),
    .ack_clr_i    (ack_clr),
    .irr_o        (irr)
  );

  pic_prio_resolve u_resolve (
    .irr_i      (irr),
    .imr_i      (imr),
    .isr_i      (isr),
    .base_i     (base),
    .smm_i      (smm),
    .nested_i   (nested),
    .master_i   (master_i),
    .int_o      (int_o),
    .line_o     (ack_line_o),
    .spurious_o (ack_spurious_o)
  );

  pic_service_ctrl u_service (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .ack_i          (ack_i),
    .cmd_valid_i    (cmd_valid_i),
    .cmd_op_i       (cmd_op_i),
    .cmd_line_i     (cmd_line_i),
    .mask_we_i      (mask_we_i),
    .mask_i         (mask_i),
    .cfg_we_i       (cfg_we_i),
    .cfg_smm_i      (cfg_smm_i),
    .cfg_nested_i   (cfg_nested_i),
    .cfg_aeoi_i     (cfg_aeoi_i),
    .cfg_rot_aeoi_i (cfg_rot_aeoi_i),
    .trig_level_i   (trig_level_i),
    .int_i          (int_o),
    .line_i         (ack_line_o),
    .isr_o          (isr),
    .imr_o          (imr),
    .base_o         (base),
    .smm_o          (smm),
    .nested_o       (nested),
    .ack_clr_o      (ack_clr)
  );

  // R4
  int_needs_request_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int_o |-> ((irr & ~imr) != '0));
endmodule

// File: tb/pic_core_bench.sv
module pic_core_bench;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic [7:0] irq = '0, lvl = '0, mask = '0;
  logic       master = 1'b0, mwe = 1'b0, cfg_we = 1'b0;
  logic       smm = 1'b0, nest = 1'b0, aeoi = 1'b0, rot = 1'b0;
  logic       cv = 1'b0, ack = 1'b0;
  logic [2:0] op = '0, ln = '0;
  logic       int_o, spur_o;
  logic [2:0] line_o;
  int         total = 0, fails = 0;
  bit         done = 1'b0;

  always #4 clk = ~clk;

  pic_core u_pic_core (
    .clk_i(clk), .rst_ni(rst_ni), .irq_i(irq), .trig_level_i(lvl), .master_i(master),
    .mask_we_i(mwe), .mask_i(mask), .cfg_we_i(cfg_we), .cfg_smm_i(smm),
    .cfg_nested_i(nest), .cfg_aeoi_i(aeoi), .cfg_rot_aeoi_i(rot),
    .cmd_valid_i(cv), .cmd_op_i(op), .cmd_line_i(ln), .ack_i(ack),
    .int_o(int_o), .ack_line_o(line_o), .ack_spurious_o(spur_o)
  );

  typedef struct packed {
    logic [7:0] irq;
    logic [7:0] lvl;
    logic       mwe;
    logic [7:0] mask;
    logic       cv;
    logic [2:0] op;
    logic [2:0] ln;
    logic       ack;
    logic       e_int;
    logic [2:0] e_line;
    logic [3:0] req;
  } vec_t;

  localparam int NV = 24;
  localparam vec_t VECS [NV] = '{
    '{8'h00, 8'h00, 1'b0, 8'h00, 1'b0, 3'd0, 3'd0, 1'b0, 1'b0, 3'd7, 4'd1},  // R1 idle
    '{8'h20, 8'h00, 1'b0, 8'h00, 1'b0, 3'd0, 3'd0, 1'b0, 1'b1, 3'd5, 4'd2},  // R2 rise
    '{8'h28, 8'h00, 1'b0, 8'h00, 1'b0, 3'd0, 3'd0, 1'b0, 1'b1, 3'd3, 4'd5},  // R5 order
    '{8'h28, 8'h00, 1'b0, 8'h00, 1'b0, 3'd0, 3'd0, 1'b1, 1'b0, 3'd7, 4'd6},  // R6 ack
    '{8'h29, 8'h00, 1'b0, 8'h00, 1'b0, 3'd0, 3'd0, 1'b0, 1'b1, 3'd0, 4'd4},  // R4 nest
    '{8'h29, 8'h00, 1'b0, 8'h00, 1'b0, 3'd0, 3'd0, 1'b1, 1'b0, 3'd7, 4'd6},  // R6
    '{8'h29, 8'h00, 1'b0, 8'h00, 1'b1, 3'd1, 3'd0, 1'b0, 1'b0, 3'd7, 4'd9},  // R9
    '{8'h29, 8'h00, 1'b0, 8'h00, 1'b1, 3'd1, 3'd0, 1'b0, 1'b1, 3'd5, 4'd9},  // R9
    '{8'h00, 8'h00, 1'b0, 8'h00, 1'b0, 3'd0, 3'd0, 1'b0, 1'b1, 3'd5, 4'd2},  // R2 fall
    '{8'h00, 8'h00, 1'b1, 8'h20, 1'b0, 3'd0, 3'd0, 1'b0, 1'b0, 3'd7, 4'd4},  // R4 mask
    '{8'h00, 8'h00, 1'b1, 8'h00, 1'b0, 3'd0, 3'd0, 1'b0, 1'b1, 3'd5, 4'd4},  // R4
    '{8'h00, 8'h00, 1'b0, 8'h00, 1'b0, 3'd0, 3'd0, 1'b1, 1'b0, 3'd7, 4'd6},  // R6
    '{8'h00, 8'h00, 1'b0, 8'h00, 1'b1, 3'd2, 3'd0, 1'b0, 1'b0, 3'd7, 4'd9},  // R9 rot
    '{8'h41, 8'h00, 1'b0, 8'h00, 1'b0, 3'd0, 3'd0, 1'b0, 1'b1, 3'd6, 4'd5},  // R5 wrap
    '{8'h41, 8'h00, 1'b0, 8'h00, 1'b1, 3'd4, 3'd6, 1'b0, 1'b1, 3'd0, 4'd10}, // R10 base
    '{8'h41, 8'h00, 1'b0, 8'h00, 1'b0, 3'd0, 3'd0, 1'b1, 1'b0, 3'd7, 4'd6},  // R6
    '{8'h41, 8'h00, 1'b0, 8'h00, 1'b1, 3'd3, 3'd0, 1'b0, 1'b1, 3'd6, 4'd10}, // R10 spec
    '{8'h41, 8'h00, 1'b0, 8'h00, 1'b0, 3'd0, 3'd0, 1'b1, 1'b0, 3'd7, 4'd6},  // R6
    '{8'h41, 8'h00, 1'b0, 8'h00, 1'b1, 3'd5, 3'd6, 1'b0, 1'b0, 3'd7, 4'd10}, // R10 both
    '{8'h00, 8'h00, 1'b0, 8'h00, 1'b0, 3'd0, 3'd0, 1'b0, 1'b0, 3'd7, 4'd2},  // R2
    '{8'h04, 8'h04, 1'b0, 8'h00, 1'b0, 3'd0, 3'd0, 1'b0, 1'b1, 3'd2, 4'd3},  // R3
    '{8'h04, 8'h04, 1'b0, 8'h00, 1'b0, 3'd0, 3'd0, 1'b1, 1'b0, 3'd7, 4'd6},  // R6 level
    '{8'h04, 8'h04, 1'b0, 8'h00, 1'b1, 3'd3, 3'd2, 1'b0, 1'b1, 3'd2, 4'd6},  // R6 kept
    '{8'h00, 8'h04, 1'b0, 8'h00, 1'b0, 3'd0, 3'd0, 1'b0, 1'b0, 3'd7, 4'd3}   // R3 drop
  };

  task automatic check_out(input logic e_int, input logic [2:0] e_line, input string tag);
    total++;
    if (int_o !== e_int || line_o !== e_line || spur_o !== !e_int) begin
      fails++;
      $display("FAIL %s: int=%0b line=%0d spur=%0b, expected int=%0b line=%0d spur=%0b",
               tag, int_o, line_o, spur_o, e_int, e_line, !e_int);
    end
  endtask

  task automatic step(input logic [7:0] i_irq, input logic i_mwe, input logic [7:0] i_mask,
                      input logic i_cv, input logic [2:0] i_op, input logic [2:0] i_ln,
                      input logic i_ack);
    irq = i_irq; mwe = i_mwe; mask = i_mask; cv = i_cv; op = i_op; ln = i_ln; ack = i_ack;
    @(negedge clk);
    mwe = 1'b0; cv = 1'b0; ack = 1'b0;
  endtask

  task automatic set_cfg(input logic s, input logic n, input logic a, input logic r);
    smm = s; nest = n; aeoi = a; rot = r; cfg_we = 1'b1;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic do_reset();
    irq = '0; lvl = '0; ack = 1'b0; cv = 1'b0; mwe = 1'b0;
    rst_ni = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst_ni = 1'b1;
  endtask

  initial begin
    @(negedge clk);
    @(negedge clk);
    check_out(1'b0, 3'd7, "R1 reset");
    rst_ni = 1'b1;
    for (int v = 0; v < NV; v++) begin
      lvl = VECS[v].lvl;
      step(VECS[v].irq, VECS[v].mwe, VECS[v].mask, VECS[v].cv, VECS[v].op, VECS[v].ln, VECS[v].ack);
      check_out(VECS[v].e_int, VECS[v].e_line, $sformatf("R%0d vec %0d", VECS[v].req, v));
    end

    // R1: mask and requests cleared by reset
    step(8'h02, 1'b1, 8'hFF, 1'b0, 3'd0, 3'd0, 1'b0);
    step(8'h02, 1'b0, 8'hFF, 1'b0, 3'd0, 3'd0, 1'b0);
    check_out(1'b0, 3'd7, "R1 masked before reset");
    do_reset();
    check_out(1'b0, 3'd7, "R1 after reset");
    step(8'h02, 1'b0, 8'h00, 1'b0, 3'd0, 3'd0, 1'b0);
    check_out(1'b1, 3'd1, "R1 mask cleared");

    // R7: spurious acknowledge does nothing
    do_reset();
    step(8'h00, 1'b0, 8'h00, 1'b0, 3'd0, 3'd0, 1'b1);
    check_out(1'b0, 3'd7, "R7 spurious ack");
    step(8'h80, 1'b0, 8'h00, 1'b0, 3'd0, 3'd0, 1'b0);
    check_out(1'b1, 3'd7, "R7 line7 not in service");

    // R8: automatic EOI with rotation
    do_reset();
    set_cfg(1'b0, 1'b0, 1'b1, 1'b1);
    step(8'h10, 1'b0, 8'h00, 1'b0, 3'd0, 3'd0, 1'b0);
    check_out(1'b1, 3'd4, "R8 line4 pending");
    step(8'h10, 1'b0, 8'h00, 1'b0, 3'd0, 3'd0, 1'b1);
    check_out(1'b0, 3'd7, "R8 after auto ack");
    step(8'h52, 1'b0, 8'h00, 1'b0, 3'd0, 3'd0, 1'b0);
    check_out(1'b1, 3'd6, "R8 base rotated to 5");
    step(8'h52, 1'b0, 8'h00, 1'b0, 3'd0, 3'd0, 1'b1);
    check_out(1'b1, 3'd1, "R8 no in-service bit set");

    // R13 then R11: special mask mode
    do_reset();
    step(8'h08, 1'b0, 8'h00, 1'b0, 3'd0, 3'd0, 1'b0);
    step(8'h08, 1'b0, 8'h00, 1'b0, 3'd0, 3'd0, 1'b1);
    step(8'h28, 1'b0, 8'h00, 1'b0, 3'd0, 3'd0, 1'b0);
    check_out(1'b0, 3'd7, "R4 blocked by in-service 3");
    step(8'h28, 1'b0, 8'h00, 1'b1, 3'd6, 3'd3, 1'b0);
    check_out(1'b0, 3'd7, "R13 code 6 no effect");
    step(8'h28, 1'b0, 8'h00, 1'b1, 3'd0, 3'd3, 1'b0);
    check_out(1'b0, 3'd7, "R13 code 0 no effect");
    step(8'h28, 1'b0, 8'h00, 1'b1, 3'd7, 3'd3, 1'b0);
    check_out(1'b0, 3'd7, "R13 code 7 no effect");
    step(8'h28, 1'b1, 8'h08, 1'b0, 3'd0, 3'd0, 1'b0);
    set_cfg(1'b1, 1'b0, 1'b0, 1'b0);
    check_out(1'b1, 3'd5, "R11 special mask on");
    set_cfg(1'b0, 1'b0, 1'b0, 1'b0);
    check_out(1'b0, 3'd7, "R11 special mask off");

    // R13: acknowledge beats a same-cycle command
    do_reset();
    step(8'h08, 1'b0, 8'h00, 1'b0, 3'd0, 3'd0, 1'b0);
    step(8'h08, 1'b0, 8'h00, 1'b1, 3'd4, 3'd4, 1'b1);
    step(8'h28, 1'b0, 8'h00, 1'b0, 3'd0, 3'd0, 1'b0);
    check_out(1'b0, 3'd7, "R13 ack wins, base unchanged");

    // R12: fully nested on a master
    do_reset();
    master = 1'b1;
    set_cfg(1'b0, 1'b1, 1'b0, 1'b0);
    step(8'h04, 1'b0, 8'h00, 1'b0, 3'd0, 3'd0, 1'b0);
    step(8'h04, 1'b0, 8'h00, 1'b0, 3'd0, 3'd0, 1'b1);
    step(8'h00, 1'b0, 8'h00, 1'b0, 3'd0, 3'd0, 1'b0);
    step(8'h04, 1'b0, 8'h00, 1'b0, 3'd0, 3'd0, 1'b0);
    check_out(1'b1, 3'd2, "R12 line2 re-enters");
    master = 1'b0;
    #1;
    check_out(1'b0, 3'd7, "R12 not master");
    master = 1'b1;

    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", total, fails);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      total++;
      fails++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", total, fails);
      $finish;
    end
  end
endmodule